// File: doc/BRIEF.md
# Hot-Swap Turn-On Sequencer with Shared Fault Timer

This block is the digital sequencing core of a hot-swap controller for a board plugged into a live supply. It reads comparator flags produced elsewhere (start threshold passed, undervoltage OK, overvoltage, current or power limiting active, circuit-breaker trip). From them it drives a two-bit gate command for the external pass switch. The analog gate regulation and the comparators sit outside this block.

One saturating counter stands in for the external timing capacitor. It serves as the insertion delay, the fault timeout and the restart delay, and each of these phases uses its own charge and discharge rate. After a fault the block can either latch off or retry. A strap selects how many automatic restarts are allowed. Each restart waits out a fixed number of timer swings between an upper and a lower threshold, then a final discharge to a re-enable level.

Fault and default-configuration events are held in sticky status bits, which are cleared only by a pulse on `clear_faults`. Each bit can be masked from the alert line. The block has no data streams, so all pins are plain control and status levels without handshakes.

Top module: `hotswap_seq`

## Requirements
- R1: While `supply_ok` is low, the gate command is 0 (strong pull-down) from the next cycle on, and the timer is held at zero.
- R2: When `supply_ok` rises, an insertion period runs with the gate at 1 (weak pull-down), whatever `uv_ok` says. The period lasts about UPPER/INS_RATE cycles. The timer then drops to zero at DIS_RATE per cycle. The gate becomes 2 (on) only once `uv_ok`=1, `ov_flag`=0 and `sw_on`=1.
- R3: A limiting episode that ends before the timer reaches UPPER declares no fault. The gate stays 2 and no status bit is set.
- R4: If limiting lasts until the timer, ramping by FLT_UP per cycle from zero, reaches UPPER, a fault is declared. The gate goes to 1, and status bit 0 (input overcurrent) is set.
- R5: While the gate is on, a circuit-breaker trip forces gate code 0 in the same cycle, sets status bit 1, and runs the fault timer. When the trip clears before timeout, the gate returns to 2. A trip that reaches timeout is a fault as in R4.
- R6: With `ov_flag`=1 or `uv_ok`=0, the gate is not 2 in the following cycle. There is no timer delay.
- R7: With `retry_mode`=0, a faulted gate stays at 1 until `sw_on` goes low, `uv_ok` goes low, or `supply_ok` goes low. Clearing it by `sw_on` or `uv_ok` lets the gate return to 2 within a few cycles.
- R8: With `retry_mode`=1, the number of automatic restarts depends on `retry_sel`: 0 gives 0, 1 gives 1, 2 gives 2, 3 gives 4, 4 gives 8, 5 gives 16, and 6 or 7 gives unlimited. The budget is reloaded at power-on and when a latch is cleared.
- R9: Each restart delay is RESTART_CYCLES down/up swings between UPPER and LOWER (down at FLT_DN, up at FLT_UP per cycle), followed by a discharge to REEN, before turn-on is tried again.
- R10: Status bits are sticky. Bit 0 is overcurrent fault, bit 1 is breaker trip, and bit 2 is configuration default, which is set by reset. A `clear_faults` pulse clears all of them. `alert` is high exactly when some status bit is set whose `alert_mask` bit is 0.
- R11: Gate code 3 is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above start threshold |
| uv_ok | input | 1 | Undervoltage comparator reports OK (also enable) |
| ov_flag | input | 1 | Overvoltage present |
| limit_act | input | 1 | Current or power limiting active |
| cb_trip | input | 1 | Circuit-breaker comparator tripped |
| retry_mode | input | 1 | 0 latch off after fault, 1 retry |
| retry_sel | input | 3 | Restart budget code (see R8) |
| sw_on | input | 1 | Software on command (level; low turns off and clears a latch) |
| clear_faults | input | 1 | One-cycle pulse clearing all status bits |
| alert_mask | input | 3 | Per status bit: 1 keeps it off the alert line |
| gate_cmd | output | 2 | 0 strong pull-down, 1 weak pull-down, 2 on |
| status | output | 3 | Sticky status bits (see R10) |
| alert | output | 1 | Alert line, active high |

## Verification
A wrong timer state shows up as a shifted turn-on or fault instant. An insertion or fault timeout that ends early or late by more than a few cycles moves the gate edge outside windows computed from the rates and thresholds. A wrong swing count in the restart logic alters the off-gap between restarts by whole swings, which amounts to hundreds of cycles. A wrong retry budget changes how many turn-on edges follow a held limit condition, which becomes visible one restart delay after the expected last attempt. A missed immediate shutdown on overvoltage, undervoltage or breaker trip shows on the gate within one cycle.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    GATE_STRONG = 2'd0,
    GATE_WEAK   = 2'd1,
    GATE_ON     = 2'd2
  } gate_e;

  typedef enum logic [2:0] {
    ST_POR,
    ST_INSERT,
    ST_DISCH,
    ST_WAIT,
    ST_RUN,
    ST_RESTART,
    ST_REEN,
    ST_LATCH
  } state_e;

  typedef enum logic [2:0] {
    T_HOLD,
    T_CLEAR,
    T_UP_SLOW,
    T_UP_FAST,
    T_DN_SLOW,
    T_DN_FAST
  } tmr_op_e;

  localparam int STAT_W   = 3;
  localparam int STAT_OC  = 0;
  localparam int STAT_CB  = 1;
  localparam int STAT_CFG = 2;

endpackage

// File: rtl/hs_timer.sv
module hs_timer
  import hs_pkg::*;
#(
  parameter int TW       = 12,
  parameter int UPPER    = 390,
  parameter int LOWER    = 120,
  parameter int REEN     = 30,
  parameter int INS_RATE = 3,
  parameter int FLT_UP   = 20,
  parameter int FLT_DN   = 2,
  parameter int DIS_RATE = 50
) (
  input  logic    clk,
  input  logic    rst_n,
  input  tmr_op_e op,
  output logic    at_upper,
  output logic    at_lower,
  output logic    at_reen,
  output logic    at_zero
);

  localparam logic [TW-1:0] T_MAX   = '1;
  localparam logic [TW-1:0] T_UPPER = TW'(UPPER);
  localparam logic [TW-1:0] T_LOWER = TW'(LOWER);
  localparam logic [TW-1:0] T_REEN  = TW'(REEN);

  logic [TW-1:0] cnt_q, cnt_d, rate;
  logic [TW:0]   sum;
  logic          going_up;

  always_comb begin
    rate     = '0;
    going_up = 1'b0;
    unique case (op)
      T_UP_SLOW: begin rate = TW'(INS_RATE); going_up = 1'b1; end
      T_UP_FAST: begin rate = TW'(FLT_UP);   going_up = 1'b1; end
      T_DN_SLOW: rate = TW'(FLT_DN);
      T_DN_FAST: rate = TW'(DIS_RATE);
      default:   rate = '0;
    endcase
  end

  assign sum = {1'b0, cnt_q} + {1'b0, rate};

  always_comb begin
    cnt_d = cnt_q;
    if (op == T_CLEAR)
      cnt_d = '0;
    else if (op != T_HOLD) begin
      if (going_up)
        cnt_d = sum[TW] ? T_MAX : sum[TW-1:0];
      else
        cnt_d = (cnt_q >= rate) ? (cnt_q - rate) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_upper = (cnt_q >= T_UPPER);
  assign at_lower = (cnt_q <= T_LOWER);
  assign at_reen  = (cnt_q <= T_REEN);
  assign at_zero  = (cnt_q == '0);

endmodule

// File: rtl/hs_retry.sv
module hs_retry #(
  parameter int MAX_EXP = 4,
  localparam int SEL_W  = $clog2(MAX_EXP + 3),
  localparam int CW     = MAX_EXP + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SEL_W-1:0] sel,
  input  logic             dec,
  output logic             may_retry
);

  logic [CW-1:0] remain_q;
  logic          unlimited_q;

  function automatic logic [CW-1:0] budget(input logic [SEL_W-1:0] code);
    if (code == '0 || int'(code) > MAX_EXP + 1)
      return '0;
    return CW'(1) << (code - SEL_W'(1));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q    <= '0;
      unlimited_q <= 1'b0;
    end else if (load) begin
      remain_q    <= budget(sel);
      unlimited_q <= (int'(sel) > MAX_EXP + 1);
    end else if (dec && remain_q != '0) begin
      remain_q    <= remain_q - CW'(1);
    end
  end

  assign may_retry = unlimited_q || (remain_q != '0);

endmodule

// File: rtl/hs_status.sv
module hs_status #(
  parameter int            W       = 3,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] bits,
  output logic         alert
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bits[b] <= RST_VAL[b];
      else if (set[b]) bits[b] <= 1'b1;
      else if (clr)    bits[b] <= 1'b0;
    end
  end

  assign alert = |(bits & ~mask);

endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
  import hs_pkg::*;
#(
  parameter int RESTART_CYCLES = 8,
  localparam int CYW = (RESTART_CYCLES > 1) ? $clog2(RESTART_CYCLES) : 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    supply_ok,
  input  logic    uv_ok,
  input  logic    ov_flag,
  input  logic    limit_act,
  input  logic    cb_trip,
  input  logic    retry_mode,
  input  logic    sw_on,
  input  logic    at_upper,
  input  logic    at_lower,
  input  logic    at_reen,
  input  logic    at_zero,
  input  logic    may_retry,
  output state_e  st,
  output gate_e   gate,
  output tmr_op_e op,
  output logic    retry_load,
  output logic    retry_dec,
  output logic    set_oc,
  output logic    set_cb
);

  state_e         st_d;
  logic           dn_q, dn_d;
  logic [CYW-1:0] cyc_q, cyc_d;
  logic           stress;

  assign stress = limit_act || cb_trip;

  always_comb begin
    st_d       = st;
    dn_d       = dn_q;
    cyc_d      = cyc_q;
    gate       = GATE_WEAK;
    op         = T_HOLD;
    retry_load = 1'b0;
    retry_dec  = 1'b0;
    set_oc     = 1'b0;
    set_cb     = 1'b0;

    unique case (st)
      ST_POR: begin
        gate       = GATE_STRONG;
        op         = T_CLEAR;
        retry_load = 1'b1;
        st_d       = ST_INSERT;
      end

      ST_INSERT: begin
        if (at_upper) begin
          op   = T_DN_FAST;
          st_d = ST_DISCH;
        end else begin
          op   = T_UP_SLOW;
        end
      end

      ST_DISCH: begin
        op = T_DN_FAST;
        if (at_zero) st_d = ST_WAIT;
      end

      ST_WAIT: begin
        op = T_DN_SLOW;
        if (!sw_on || !uv_ok) retry_load = 1'b1;
        else if (!ov_flag)    st_d = ST_RUN;
      end

      ST_RUN: begin
        gate   = cb_trip ? GATE_STRONG : GATE_ON;
        set_cb = cb_trip;
        if (ov_flag || !uv_ok || !sw_on) begin
          op   = T_DN_SLOW;
          st_d = ST_WAIT;
        end else if (stress && at_upper) begin
          set_oc = 1'b1;
          if (retry_mode && may_retry) begin
            retry_dec = 1'b1;
            dn_d      = 1'b1;
            cyc_d     = '0;
            st_d      = ST_RESTART;
          end else begin
            st_d      = ST_LATCH;
          end
        end else if (stress) begin
          op = T_UP_FAST;
        end else begin
          op = T_DN_SLOW;
        end
      end

      ST_RESTART: begin
        if (!sw_on) begin
          op   = T_DN_SLOW;
          st_d = ST_WAIT;
        end else if (dn_q) begin
          op = T_DN_SLOW;
          if (at_lower) begin
            if (cyc_q == CYW'(RESTART_CYCLES - 1)) st_d = ST_REEN;
            else begin
              cyc_d = cyc_q + CYW'(1);
              dn_d  = 1'b0;
            end
          end
        end else begin
          op = T_UP_FAST;
          if (at_upper) dn_d = 1'b1;
        end
      end

      ST_REEN: begin
        op = T_DN_SLOW;
        if (at_reen || !sw_on) st_d = ST_WAIT;
      end

      ST_LATCH: begin
        op = T_DN_SLOW;
        if (!sw_on || !uv_ok) begin
          retry_load = 1'b1;
          st_d       = ST_WAIT;
        end
      end

      default: st_d = ST_POR;
    endcase

    if (!supply_ok) begin
      st_d = ST_POR;
      op   = T_CLEAR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_POR;
      dn_q  <= 1'b1;
      cyc_q <= '0;
    end else begin
      st    <= st_d;
      dn_q  <= dn_d;
      cyc_q <= cyc_d;
    end
  end

endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq
  import hs_pkg::*;
#(
  parameter int TW             = 12,
  parameter int UPPER          = 390,
  parameter int LOWER          = 120,
  parameter int REEN           = 30,
  parameter int INS_RATE       = 3,
  parameter int FLT_UP         = 20,
  parameter int FLT_DN         = 2,
  parameter int DIS_RATE       = 50,
  parameter int RESTART_CYCLES = 8,
  parameter int MAX_EXP        = 4,
  localparam int SEL_W         = $clog2(MAX_EXP + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              uv_ok,
  input  logic              ov_flag,
  input  logic              limit_act,
  input  logic              cb_trip,
  input  logic              retry_mode,
  input  logic [SEL_W-1:0]  retry_sel,
  input  logic              sw_on,
  input  logic              clear_faults,
  input  logic [STAT_W-1:0] alert_mask,
  output logic [1:0]        gate_cmd,
  output logic [STAT_W-1:0] status,
  output logic              alert
);

  state_e  st;
  gate_e   gate;
  tmr_op_e op;
  logic    at_upper, at_lower, at_reen, tmr_zero;
  logic    may_retry, retry_load, retry_dec, set_oc, set_cb;
  logic [STAT_W-1:0] stat_set;

  hs_timer #(
    .TW(TW), .UPPER(UPPER), .LOWER(LOWER), .REEN(REEN),
    .INS_RATE(INS_RATE), .FLT_UP(FLT_UP), .FLT_DN(FLT_DN), .DIS_RATE(DIS_RATE)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .op(op),
    .at_upper(at_upper), .at_lower(at_lower), .at_reen(at_reen), .at_zero(tmr_zero)
  );

  hs_retry #(.MAX_EXP(MAX_EXP)) u_retry (
    .clk(clk), .rst_n(rst_n), .load(retry_load), .sel(retry_sel),
    .dec(retry_dec), .may_retry(may_retry)
  );

  hs_fsm #(.RESTART_CYCLES(RESTART_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .uv_ok(uv_ok),
    .ov_flag(ov_flag), .limit_act(limit_act), .cb_trip(cb_trip),
    .retry_mode(retry_mode), .sw_on(sw_on), .at_upper(at_upper),
    .at_lower(at_lower), .at_reen(at_reen), .at_zero(tmr_zero),
    .may_retry(may_retry), .st(st), .gate(gate), .op(op),
    .retry_load(retry_load), .retry_dec(retry_dec),
    .set_oc(set_oc), .set_cb(set_cb)
  );

  always_comb begin
    stat_set           = '0;
    stat_set[STAT_OC]  = set_oc;
    stat_set[STAT_CB]  = set_cb;
  end

  hs_status #(.W(STAT_W), .RST_VAL(STAT_W'(1) << STAT_CFG)) u_status (
    .clk(clk), .rst_n(rst_n), .set(stat_set), .clr(clear_faults),
    .mask(alert_mask), .bits(status), .alert(alert)
  );

  assign gate_cmd = gate;

endmodule

// File: rtl/hs_checker.sv
module hs_checker
  import hs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              uv_ok,
  input logic              ov_flag,
  input logic              cb_trip,
  input logic              sw_on,
  input logic              clear_faults,
  input logic [1:0]        gate_cmd,
  input logic [STAT_W-1:0] status,
  input logic              alert,
  input state_e            st,
  input logic              tmr_zero
);

  assert_gate_strong_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> gate_cmd == GATE_STRONG);

  assert_timer_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POR) |=> tmr_zero);

  assert_insert_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INSERT) |-> gate_cmd == GATE_WEAK);

  assert_breaker_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_trip && st == ST_RUN) |=> status[STAT_CB]);

  assert_ov_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag |=> gate_cmd != GATE_ON);

  assert_uv_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok |=> gate_cmd != GATE_ON);

  assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LATCH && supply_ok && uv_ok && sw_on) |=> st == ST_LATCH);

  assert_alert_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert) |-> status != '0);

  assert_cfg_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_faults |=> !status[STAT_CFG]);

  assert_gate_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gate_cmd != 2'd3);

endmodule

bind hotswap_seq hs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .uv_ok(uv_ok),
  .ov_flag(ov_flag), .cb_trip(cb_trip), .sw_on(sw_on),
  .clear_faults(clear_faults), .gate_cmd(gate_cmd), .status(status),
  .alert(alert), .st(st), .tmr_zero(tmr_zero)
);

// File: tb/hotswap_seq_test.sv
module hotswap_seq_test;

  localparam int UPPER = 390, LOWER = 120, REEN = 30;
  localparam int INS_RATE = 3, FLT_UP = 20, FLT_DN = 2, DIS_RATE = 50;
  localparam int RCYC = 8;
  localparam logic [1:0] G_STRONG = 2'd0, G_WEAK = 2'd1, G_ON = 2'd2;
  // retry_sel code, expected restarts (-1 = unlimited, capped at 20)
  localparam int TBL [7][2] = '{'{0, 0}, '{1, 1}, '{2, 2}, '{3, 4},
                                '{4, 8}, '{5, 16}, '{6, -1}};
  localparam int GAP_LO = RCYC * ((UPPER - LOWER) / FLT_DN)
                        + (RCYC - 1) * ((UPPER - LOWER) / FLT_UP)
                        + (LOWER - REEN) / FLT_DN;

  logic clk = 0, rst_n = 0;
  logic supply_ok = 0, uv_ok = 1, ov_flag = 0, limit_act = 0, cb_trip = 0;
  logic retry_mode = 0, sw_on = 1, clear_faults = 0;
  logic [2:0] retry_sel = 0, alert_mask = 0;
  logic [1:0] gate_cmd;
  logic [2:0] status;
  logic alert;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hotswap_seq uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .uv_ok(uv_ok),
    .ov_flag(ov_flag), .limit_act(limit_act), .cb_trip(cb_trip),
    .retry_mode(retry_mode), .retry_sel(retry_sel), .sw_on(sw_on),
    .clear_faults(clear_faults), .alert_mask(alert_mask),
    .gate_cmd(gate_cmd), .status(status), .alert(alert)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_gate(input logic [1:0] code, input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (gate_cmd == code) break;
    end
  endtask

  task automatic pulse_clear();
    clear_faults = 1; tick(1); clear_faults = 0;
  endtask

  bit saw_illegal = 0;
  always @(negedge clk) if (rst_n && gate_cmd == 2'd3) saw_illegal = 1;

  initial begin
    int n;
    tick(5);
    chk("R1 reset gate", gate_cmd, G_STRONG);
    chk("R10 reset status", status, 3'b100);
    chk("R10 reset alert", alert, 1);
    rst_n = 1; tick(2);
    alert_mask = 3'b100; tick(1);
    chk("R10 masked cfg alert", alert, 0);
    alert_mask = 0; pulse_clear(); tick(1);
    chk("R10 clear status", status, 0);
    chk("R10 clear alert", alert, 0);

    // insertion with undervoltage not OK
    uv_ok = 0; supply_ok = 1; tick(100);
    chk("R2 insert weak", gate_cmd, G_WEAK);
    tick(100);
    chk("R2 waits for uv", gate_cmd, G_WEAK);
    uv_ok = 1; wait_gate(G_ON, 10, n);
    chk_rng("R2 on after uv", n, 1, 3);

    // short limiting episode
    tick(150);
    limit_act = 1; tick(10); limit_act = 0; tick(200);
    chk("R3 still on", gate_cmd, G_ON);
    chk("R3 no status", status, 0);

    // sustained limiting, latch mode
    limit_act = 1; wait_gate(G_WEAK, 100, n);
    chk_rng("R4 timeout", n, UPPER / FLT_UP, UPPER / FLT_UP + 5);
    chk("R4 oc status", status, 3'b001);
    chk("R4 alert", alert, 1);
    alert_mask = 3'b001; tick(1);
    chk("R10 mask oc", alert, 0);
    alert_mask = 0;
    limit_act = 0; tick(300);
    chk("R7 latched", gate_cmd, G_WEAK);
    sw_on = 0; tick(2); sw_on = 1; wait_gate(G_ON, 10, n);
    chk_rng("R7 sw restart", n, 1, 3);

    tick(300);
    limit_act = 1; wait_gate(G_WEAK, 100, n); limit_act = 0; tick(20);
    chk("R7 latched again", gate_cmd, G_WEAK);
    uv_ok = 0; tick(2); uv_ok = 1; wait_gate(G_ON, 10, n);
    chk_rng("R7 uv restart", n, 1, 3);

    tick(300);
    limit_act = 1; wait_gate(G_WEAK, 100, n); limit_act = 0; tick(5);
    supply_ok = 0; tick(1);
    chk("R1 supply drop", gate_cmd, G_STRONG);
    tick(5);
    supply_ok = 1; wait_gate(G_ON, 400, n);
    chk_rng("R2 insertion length", n, UPPER / INS_RATE,
            UPPER / INS_RATE + UPPER / DIS_RATE + 10);

    // circuit breaker
    pulse_clear(); tick(150);
    cb_trip = 1; tick(1);
    chk("R5 strong on trip", gate_cmd, G_STRONG);
    tick(3);
    chk("R5 cb status", status, 3'b010);
    chk("R5 cb alert", alert, 1);
    cb_trip = 0; tick(1);
    chk("R5 back on", gate_cmd, G_ON);
    tick(50);
    chk("R10 sticky", status, 3'b010);
    pulse_clear(); tick(200);
    cb_trip = 1; tick(40); cb_trip = 0; tick(2);
    chk("R5 cb timeout", gate_cmd, G_WEAK);
    chk("R5 cb fault status", status, 3'b011);
    sw_on = 0; tick(2); sw_on = 1; wait_gate(G_ON, 10, n);
    pulse_clear(); tick(300);

    // overvoltage / undervoltage
    ov_flag = 1; tick(1);
    chk("R6 ov off", gate_cmd, G_WEAK);
    ov_flag = 0; wait_gate(G_ON, 10, n);
    chk_rng("R6 ov recover", n, 1, 3);
    uv_ok = 0; tick(1);
    chk("R6 uv off", gate_cmd, G_WEAK);
    uv_ok = 1; wait_gate(G_ON, 10, n);
    chk_rng("R6 uv recover", n, 1, 3);

    // retry budget table
    for (int i = 0; i < 7; i++) begin
      int ons, idle, offc, gap, exp_n;
      bit was_on;
      limit_act = 0; retry_mode = 1; retry_sel = 3'(TBL[i][0]);
      sw_on = 0; tick(3); sw_on = 1; wait_gate(G_ON, 10, n);
      limit_act = 1;
      ons = 0; idle = 0; offc = 0; gap = -1; was_on = 1;
      exp_n = (TBL[i][1] < 0) ? 20 : TBL[i][1];
      for (int c = 0; c < 60000 && idle < 2500 && ons < 20; c++) begin
        @(negedge clk);
        if (gate_cmd == G_ON) begin
          if (!was_on) begin
            ons++;
            if (ons == 1) gap = offc;
          end
          was_on = 1; idle = 0;
        end else begin
          if (was_on) offc = 0;
          offc++; was_on = 0; idle++;
        end
      end
      chk($sformatf("R8 restarts sel=%0d", TBL[i][0]), ons, exp_n);
      if (exp_n > 0) chk_rng("R9 restart delay", gap, GAP_LO, GAP_LO + 300);
    end
    limit_act = 0;
    chk("R11 legal gate codes", saw_illegal, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule